// File: doc/BRIEF.md
# Cache-Block Instruction Decoder

This block classifies one 32-bit instruction word and tells whether it is a cache-block maintenance operation, a prefetch hint, or one of the two general instructions whose encoding space these operations reuse. The two general instructions are the immediate OR and the 128-bit quad load. The specific maintenance and hint patterns take precedence over the general patterns. A maintenance pattern whose extension is switched off is decoded as the general quad load.

The decoder is purely combinational and sits in the decode stage of a pipeline. It drives a one-hot class vector with ten entries. It also drives the base register index, the sign-extended prefetch offset, and a flag that marks the operations which write back a dirty block. Register reads and execution happen elsewhere.

Top module: `cbd_decoder`

## Requirements
- R1: When the opcode (bits [6:0]) is 0010011, funct3 (bits [14:12]) is 110 and rd (bits [11:7]) is 00000, the rs2 field (bits [24:20]) selects a prefetch class: 00000 sets class bit 0 (instruction prefetch), 00001 sets bit 1 (read prefetch), and 00011 sets bit 2 (write prefetch).
- R2: Every other word with opcode 0010011 and funct3 110 sets class bit 7 (immediate OR). This includes words with rd zero whose rs2 is not one of the three prefetch codes.
- R3: For the three prefetch classes, `pf_offset` is bits [31:25] taken as a signed 7-bit value and sign-extended to XLEN. For every other class it is zero.
- R4: When the opcode is 0001111, funct3 is 010, rd is 00000, bits [31:25] are all zero and `en_blk_mgmt` is 1, rs2 selects a maintenance class: 00000 sets bit 3 (invalidate), 00001 sets bit 4 (clean), and 00010 sets bit 5 (flush).
- R5: The same shape with rs2 00100 sets bit 6 (block zero) only when `en_blk_zero` is 1.
- R6: Every other word with opcode 0001111 and funct3 010 sets bit 8 (quad load). This includes a maintenance pattern whose enable is 0.
- R7: `wb_dirty` is 1 exactly when the class is clean or flush.
- R8: A word outside both spaces sets bit 9 (other). For every input exactly one class bit is 1.
- R9: `rs1_idx` always equals bits [19:15] of the word.
- R10: The prefetch classes are decoded the same way whatever the values of the two enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn | input | 32 | Instruction word to classify |
| en_blk_mgmt | input | 1 | Enables invalidate, clean and flush |
| en_blk_zero | input | 1 | Enables block zero |
| op_class | output | 10 | One-hot class, bit order as in the requirements |
| rs1_idx | output | 5 | Base register index |
| pf_offset | output | XLEN | Sign-extended prefetch offset, zero otherwise |
| wb_dirty | output | 1 | Clean or flush decoded |

## Verification
The enable gate and the fall-back to the general pattern act on the same word at the same moment. A block-zero word with only the management enable set must become a quad load. A clean word with only the zero enable set must do the same. Random words are biased into both shared spaces with rd forced to zero and rs2 drawn from the special codes, and the two enables are drawn independently. A bench function, written from the requirements, computes the expected class, offset and flag for each word. Directed words cover the off-by-one rs2 codes and a nonzero upper field.

// File: rtl/cbd_pkg.sv
package cbd_pkg;
  localparam int NCLS = 10;

  typedef enum logic [3:0] {
    CLS_PF_I  = 4'd0,
    CLS_PF_R  = 4'd1,
    CLS_PF_W  = 4'd2,
    CLS_INVAL = 4'd3,
    CLS_CLEAN = 4'd4,
    CLS_FLUSH = 4'd5,
    CLS_ZERO  = 4'd6,
    CLS_ORI   = 4'd7,
    CLS_LQ    = 4'd8,
    CLS_OTHER = 4'd9
  } cls_e;

  localparam logic [6:0] OPC_OPIMM = 7'b0010011;
  localparam logic [6:0] OPC_MISC  = 7'b0001111;
  localparam logic [2:0] F3_OR     = 3'b110;
  localparam logic [2:0] F3_LQ     = 3'b010;
endpackage

// File: rtl/cbd_hint_match.sv
module cbd_hint_match
  import cbd_pkg::*;
(
  input  logic [31:0] insn,
  output logic        in_space,
  output logic [2:0]  hit
);
  localparam int NHINT = 3;
  localparam logic [4:0] HINT_CODE [NHINT] = '{5'b00000, 5'b00001, 5'b00011};

  logic shape_ok;

  always_comb begin
    in_space = (insn[6:0] == OPC_OPIMM) && (insn[14:12] == F3_OR);
    shape_ok = in_space && (insn[11:7] == 5'd0);
  end

  for (genvar g = 0; g < NHINT; g++) begin : g_hint
    assign hit[g] = shape_ok && (insn[24:20] == HINT_CODE[g]);
  end
endmodule

// File: rtl/cbd_blk_match.sv
module cbd_blk_match
  import cbd_pkg::*;
(
  input  logic [31:0] insn,
  input  logic        en_mgmt,
  input  logic        en_zero,
  output logic        in_space,
  output logic [3:0]  hit
);
  localparam int NBLK = 4;
  localparam logic [4:0] BLK_CODE [NBLK] = '{5'b00000, 5'b00001, 5'b00010, 5'b00100};

  logic shape_ok;

  always_comb begin
    in_space = (insn[6:0] == OPC_MISC) && (insn[14:12] == F3_LQ);
    shape_ok = in_space && (insn[11:7] == 5'd0) && (insn[31:25] == 7'd0);
  end

  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    if (g < 3) begin : g_mgmt
      assign hit[g] = shape_ok && en_mgmt && (insn[24:20] == BLK_CODE[g]);
    end else begin : g_zero
      assign hit[g] = shape_ok && en_zero && (insn[24:20] == BLK_CODE[g]);
    end
  end

  always_comb begin
    a_r6_gate_mgmt: assert (en_mgmt || (hit[2:0] == 3'b000));
    a_r5_gate_zero: assert (en_zero || !hit[3]);
  end
endmodule

// File: rtl/cbd_offset_ext.sv
module cbd_offset_ext #(
  parameter int XLEN  = 64,
  parameter int OFS_W = 7
) (
  input  logic [OFS_W-1:0] field,
  input  logic             sel,
  output logic [XLEN-1:0]  offset
);
  localparam int PAD_W = XLEN - OFS_W;

  always_comb begin
    offset = sel ? {{PAD_W{field[OFS_W-1]}}, field} : '0;
  end
endmodule

// File: rtl/cbd_decoder.sv
module cbd_decoder
  import cbd_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int OFS_W = 7
) (
  input  logic [31:0]     insn,
  input  logic            en_blk_mgmt,
  input  logic            en_blk_zero,
  output logic [NCLS-1:0] op_class,
  output logic [4:0]      rs1_idx,
  output logic [XLEN-1:0] pf_offset,
  output logic            wb_dirty
);
  logic       hint_space, blk_space;
  logic [2:0] hint_hit;
  logic [3:0] blk_hit;
  logic       is_pf;

  cbd_hint_match u_hint (
    .insn     (insn),
    .in_space (hint_space),
    .hit      (hint_hit)
  );

  cbd_blk_match u_blk (
    .insn     (insn),
    .en_mgmt  (en_blk_mgmt),
    .en_zero  (en_blk_zero),
    .in_space (blk_space),
    .hit      (blk_hit)
  );

  always_comb begin
    is_pf    = |hint_hit;
    op_class = '0;
    op_class[CLS_PF_I]  = hint_hit[0];
    op_class[CLS_PF_R]  = hint_hit[1];
    op_class[CLS_PF_W]  = hint_hit[2];
    op_class[CLS_INVAL] = blk_hit[0];
    op_class[CLS_CLEAN] = blk_hit[1];
    op_class[CLS_FLUSH] = blk_hit[2];
    op_class[CLS_ZERO]  = blk_hit[3];
    op_class[CLS_ORI]   = hint_space && !is_pf;
    op_class[CLS_LQ]    = blk_space && !(|blk_hit);
    op_class[CLS_OTHER] = !hint_space && !blk_space;
    wb_dirty = blk_hit[1] || blk_hit[2];
    rs1_idx  = insn[19:15];
  end

  cbd_offset_ext #(.XLEN(XLEN), .OFS_W(OFS_W)) u_ofs (
    .field  (insn[31:32-OFS_W]),
    .sel    (is_pf),
    .offset (pf_offset)
  );

  always_comb begin
    a_r8_one_class: assert ($onehot(op_class));
    a_r3_offset_quiet: assert ((|op_class[2:0]) || (pf_offset == '0));
    a_r7_writeback: assert (wb_dirty == (op_class[CLS_CLEAN] | op_class[CLS_FLUSH]));
  end
endmodule

// File: tb/cbd_decoder_bench.sv
module cbd_decoder_bench;
  localparam int XLEN = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] insn = '0;
  logic        en_m = 1'b0, en_z = 1'b0;
  logic [9:0]  cls;
  logic [4:0]  rs1;
  logic [XLEN-1:0] ofs;
  logic        wb;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  cbd_decoder #(.XLEN(XLEN), .OFS_W(7)) u_cbd_decoder (
    .insn(insn), .en_blk_mgmt(en_m), .en_blk_zero(en_z),
    .op_class(cls), .rs1_idx(rs1), .pf_offset(ofs), .wb_dirty(wb)
  );

  function automatic int ref_cls(logic [31:0] w, logic m, logic z);
    if (w[6:0] == 7'b0010011 && w[14:12] == 3'b110) begin
      if (w[11:7] == 0 && w[24:20] == 5'd0) return 0;
      if (w[11:7] == 0 && w[24:20] == 5'd1) return 1;
      if (w[11:7] == 0 && w[24:20] == 5'd3) return 2;
      return 7;
    end
    if (w[6:0] == 7'b0001111 && w[14:12] == 3'b010) begin
      if (w[11:7] == 0 && w[31:25] == 0) begin
        if (m && w[24:20] == 5'd0) return 3;
        if (m && w[24:20] == 5'd1) return 4;
        if (m && w[24:20] == 5'd2) return 5;
        if (z && w[24:20] == 5'd4) return 6;
      end
      return 8;
    end
    return 9;
  endfunction

  task automatic apply(logic [31:0] w, logic m, logic z, string tag);
    int k;
    logic [XLEN-1:0] eo;
    @(negedge clk);
    insn = w; en_m = m; en_z = z;
    @(posedge clk); #1;
    k  = ref_cls(w, m, z);
    eo = (k <= 2) ? {{(XLEN-7){w[31]}}, w[31:25]} : '0;
    n_chk++;
    if (cls !== (10'd1 << k)) begin
      n_bad++;
      $display("FAIL %s class insn=%h act=%b exp=%b", tag, w, cls, 10'd1 << k);
    end
    n_chk++;
    if (ofs !== eo) begin
      n_bad++;
      $display("FAIL R3 offset insn=%h act=%h exp=%h", w, ofs, eo);
    end
    n_chk++;
    if (wb !== (k == 4 || k == 5)) begin
      n_bad++;
      $display("FAIL R7 wb insn=%h act=%b exp=%b", w, wb, (k == 4 || k == 5));
    end
    n_chk++;
    if (rs1 !== w[19:15]) begin
      n_bad++;
      $display("FAIL R9 rs1 insn=%h act=%0d exp=%0d", w, rs1, w[19:15]);
    end
  endtask

  function automatic logic [31:0] mk(logic [6:0] hi, logic [4:0] rs2, logic [4:0] r1,
                                     logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
    return {hi, rs2, r1, f3, rd, op};
  endfunction

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] w;
    logic [4:0] codes [6];
    codes = '{5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5};
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    apply(32'h0, 1'b0, 1'b0, "R8 reset-state");
    apply(mk(7'h40, 5'd0, 5'd9, 3'b110, 5'd0, 7'b0010011), 1'b0, 1'b0, "R1 R10 pf_i");
    apply(mk(7'h3f, 5'd1, 5'd2, 3'b110, 5'd0, 7'b0010011), 1'b1, 1'b1, "R1 pf_r");
    apply(mk(7'h7f, 5'd3, 5'd31, 3'b110, 5'd0, 7'b0010011), 1'b0, 1'b1, "R1 pf_w");
    apply(mk(7'h01, 5'd2, 5'd4, 3'b110, 5'd0, 7'b0010011), 1'b1, 1'b1, "R2 ori rs2=2");
    apply(mk(7'h00, 5'd0, 5'd4, 3'b110, 5'd1, 7'b0010011), 1'b1, 1'b1, "R2 ori rd!=0");
    apply(mk(7'h00, 5'd0, 5'd7, 3'b010, 5'd0, 7'b0001111), 1'b1, 1'b0, "R4 inval");
    apply(mk(7'h00, 5'd1, 5'd7, 3'b010, 5'd0, 7'b0001111), 1'b1, 1'b0, "R4 R7 clean");
    apply(mk(7'h00, 5'd2, 5'd7, 3'b010, 5'd0, 7'b0001111), 1'b1, 1'b0, "R4 R7 flush");
    apply(mk(7'h00, 5'd4, 5'd7, 3'b010, 5'd0, 7'b0001111), 1'b0, 1'b1, "R5 zero");
    apply(mk(7'h00, 5'd4, 5'd7, 3'b010, 5'd0, 7'b0001111), 1'b1, 1'b0, "R5 R6 zero-off");
    apply(mk(7'h00, 5'd1, 5'd7, 3'b010, 5'd0, 7'b0001111), 1'b0, 1'b1, "R6 clean-off");
    apply(mk(7'h01, 5'd0, 5'd7, 3'b010, 5'd0, 7'b0001111), 1'b1, 1'b1, "R6 hi!=0");
    apply(mk(7'h00, 5'd3, 5'd7, 3'b010, 5'd0, 7'b0001111), 1'b1, 1'b1, "R6 rs2=3");
    apply(mk(7'h00, 5'd0, 5'd7, 3'b011, 5'd0, 7'b0001111), 1'b1, 1'b1, "R8 other");
    for (int i = 0; i < 4000; i++) begin
      w = $urandom;
      case ($urandom % 3)
        0: begin w[6:0] = 7'b0010011; if ($urandom % 4 != 0) w[14:12] = 3'b110; end
        1: begin w[6:0] = 7'b0001111; if ($urandom % 4 != 0) w[14:12] = 3'b010; end
        default: ;
      endcase
      if ($urandom % 4 != 0) w[11:7] = 5'd0;
      if ($urandom % 4 != 0) w[24:20] = codes[$urandom % 6];
      if ($urandom % 2 != 0) w[31:25] = 7'd0;
      apply(w, 1'($urandom), 1'($urandom), "R1 R2 R4 R5 R6 R8 R10 random");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule